// File: doc/BRIEF.md
# Nibble-Stream Packet Buffer Port

This device-side block sits between a host that can only move four bits at a time over a parallel data port and an internal byte-wide packet buffer. On the way in, the host sends each byte as two nibbles. Bit 4 of every host byte says which half it carries: clear for the low half, set for the high half. The low half always comes first. The block pairs each low half with the high half that follows it and writes the finished byte into the buffer. The write address steps forward by one for each byte. A 16-bit word is simply two such bytes, least significant byte first.

On the way out, the host sends read commands aimed at the buffer offset. Each command selects the low or the high half of the byte at the current read address. The chosen nibble appears on status lines 6..3 and stays there until the host asks for the other half. This lets a slow host sample it as often as it likes. Packets that the network side has stored in the buffer include a leading header of four 16-bit fields: pad, byte count, status and buffer pointer. The block returns those bytes exactly like any other buffer byte.

A transmit-start pulse returns both buffer addresses to zero, so that a new packet can be loaded or read from the start.

Top module: `nibport_top`

## Requirements
- R1: After a synchronous active-low reset, `host_status` is 0x00, no buffer write is issued, and the first completed byte is written to address 0.
- R2: A host byte with bits 7:5 = 000 and bit 4 = 0 is a low nibble (bits 3:0). It is held internally and causes no buffer write.
- R3: A host byte with bits 7:5 = 000 and bit 4 = 1 that follows a held low nibble writes the byte {bits 3:0, held low nibble} at the write address. The write address then advances by one.
- R4: A high nibble with no held low nibble is discarded and writes nothing. Two low nibbles in a row keep only the later one, so assembly re-aligns on the next low nibble.
- R5: A 16-bit word sent as four nibbles, least significant first, with tags 0,1,0,1, lands as two consecutive bytes with the low byte at the lower address.
- R6: Only bytes with bits 7:5 = 000 are data nibbles. Only bytes with bits 7:5 = 110 and bits 3:0 = 14 are buffer read commands. Every other host byte changes neither the buffer, nor any pending nibble, nor `host_status`.
- R7: A read command with bit 4 = 0 puts bits 3:0 of the byte at the read address on `host_status[6:3]`, with all other status bits 0, within two cycles.
- R8: A read command with bit 4 = 1 puts bits 7:4 of that byte on `host_status[6:3]` and advances the read address by one.
- R9: A read command that selects the same half as the previous one leaves `host_status` and the read address unchanged.
- R10: A `xmit_start` pulse sets both buffer addresses to zero, drops any held low nibble, and clears `host_status` to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xmit_start | input | 1 | One-cycle pulse that restarts both buffer addresses |
| host_strobe | input | 1 | Host byte on `host_data` is valid this cycle |
| host_data | input | 8 | Byte written by the host to the data port |
| host_status | output | 8 | Status lines; the nibble sits in bits 6:3 |
| buf_we | output | 1 | Buffer write enable |
| buf_waddr | output | ADDR_W | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| buf_re | output | 1 | Buffer read enable (data returns next cycle) |
| buf_raddr | output | ADDR_W | Buffer read address |
| buf_rdata | input | 8 | Buffer read data, one cycle after `buf_re` |

## Verification
The assertions check several rules on every cycle: each buffer write advances the write address by exactly one and clears the held nibble, an orphan high nibble leaves the write address alone, a high-half read advances the read address by exactly one, a repeated same-half read leaves both the status nibble and the read address untouched, a transmit start zeroes both addresses, and reads and writes never collide. Only the bench's scenarios can show what actually lands in the buffer and comes back on the status lines. That covers the byte order of assembled bytes and words, re-alignment after stray or doubled nibbles, rejection of foreign prefixes and wrong offsets, and the correct pairing of nibbles to addresses across a full read-back.

// File: rtl/nibport_pkg.sv
// Shared definitions for the nibble-stream buffer port.
// Assumes the host byte carries a 3-bit prefix in bits 7:5, a half tag in
// bit 4 and a nibble or register offset in bits 3:0.
package nibport_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WR_LO,
        CMD_WR_HI,
        CMD_RD_LO,
        CMD_RD_HI
    } cmd_e;

    localparam logic [2:0] DATA_PREFIX   = 3'b000;
    localparam logic [2:0] READ_PREFIX   = 3'b110;
    localparam logic [3:0] BUFFER_OFFSET = 4'd14;

    // Map one host byte onto the command it represents.
    function automatic cmd_e classify(input logic [7:0] b);
        cmd_e c;
        c = CMD_NONE;
        if (b[7:5] == DATA_PREFIX)
            c = b[4] ? CMD_WR_HI : CMD_WR_LO;
        else if (b[7:5] == READ_PREFIX && b[3:0] == BUFFER_OFFSET)
            c = b[4] ? CMD_RD_HI : CMD_RD_LO;
        return c;
    endfunction

endpackage

// File: rtl/nibport_decode.sv
// Turns a strobed host byte into a command and the nibble it carries.
// Assumes at most one host byte per cycle; purely combinational.
module nibport_decode
    import nibport_pkg::*;
(
    input  logic       strobe,
    input  logic [7:0] data,
    output cmd_e       cmd,
    output logic [3:0] nib
);

    // Classify only when the host byte is valid.
    always_comb begin
        cmd = strobe ? classify(data) : CMD_NONE;
        nib = data[3:0];
    end

endmodule

// File: rtl/nibport_wr_asm.sv
// Pairs a low nibble with the following high nibble and writes the byte
// to the buffer at an address that advances per byte.
// Assumes clr (transmit start) takes priority over any command that cycle.
module nibport_wr_asm
    import nibport_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  cmd_e              cmd,
    input  logic [3:0]        nib,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_waddr,
    output logic [7:0]        buf_wdata
);

    logic              have_lo;
    logic [3:0]        lo_q;
    logic [ADDR_W-1:0] waddr_q;

    // A write happens only for a high nibble with a held low nibble.
    assign buf_we    = (cmd == CMD_WR_HI) && have_lo && !clr;
    assign buf_wdata = {nib, lo_q};
    assign buf_waddr = waddr_q;

    // Hold the low nibble, drop it once used, step the address per byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            have_lo <= 1'b0;
            lo_q    <= '0;
            waddr_q <= '0;
        end else begin
            if (cmd == CMD_WR_LO) begin
                have_lo <= 1'b1;
                lo_q    <= nib;
            end else if (cmd == CMD_WR_HI) begin
                have_lo <= 1'b0;
            end
            if (buf_we)
                waddr_q <= waddr_q + 1'b1;
        end
    end

    // Each write steps the address once and consumes the held nibble.
    assert_write_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> (waddr_q == $past(waddr_q) + 1'b1) && !have_lo);

    // An orphan high nibble leaves the write address alone.
    assert_orphan_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR_HI && !have_lo && !clr) |=> $stable(waddr_q));

    // Transmit start returns the write side to its origin.
    assert_wr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (waddr_q == '0) && !have_lo);

endmodule

// File: rtl/nibport_rd_srv.sv
// Serves buffer bytes to the host one nibble per read command. A low-half
// command fetches the byte; a high-half command returns the upper nibble
// and advances the address. Repeats of the same half are ignored.
// Assumes the buffer returns data one cycle after buf_re.
module nibport_rd_srv
    import nibport_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  cmd_e              cmd,
    output logic              buf_re,
    output logic [ADDR_W-1:0] buf_raddr,
    input  logic [7:0]        buf_rdata,
    output logic [3:0]        nib_out
);

    logic              last_hi;
    logic              fill_pend;
    logic [7:0]        byte_q;
    logic [3:0]        nib_q;
    logic [ADDR_W-1:0] raddr_q;
    logic              lo_new;
    logic              hi_new;

    // A command counts only when it switches half.
    assign lo_new    = (cmd == CMD_RD_LO) && last_hi && !clr;
    assign hi_new    = (cmd == CMD_RD_HI) && !last_hi && !clr;
    assign buf_re    = lo_new;
    assign buf_raddr = raddr_q;
    assign nib_out   = nib_q;

    // Capture the fetched byte, then serve halves and step the address.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            last_hi   <= 1'b1;
            fill_pend <= 1'b0;
            byte_q    <= '0;
            nib_q     <= '0;
            raddr_q   <= '0;
        end else begin
            fill_pend <= lo_new;
            if (fill_pend) begin
                byte_q <= buf_rdata;
                nib_q  <= buf_rdata[3:0];
            end
            if (lo_new)
                last_hi <= 1'b0;
            if (hi_new) begin
                last_hi <= 1'b1;
                nib_q   <= fill_pend ? buf_rdata[7:4] : byte_q[7:4];
                raddr_q <= raddr_q + 1'b1;
            end
        end
    end

    // A high-half read moves the read address by exactly one.
    assert_read_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_new |=> raddr_q == $past(raddr_q) + 1'b1);

    // A repeated high-half read changes nothing the host can see.
    assert_repeat_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD_HI && last_hi && !clr && !fill_pend)
            |=> $stable(nib_q) && $stable(raddr_q));

    // A repeated low-half read changes nothing the host can see.
    assert_repeat_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD_LO && !last_hi && !clr && !fill_pend)
            |=> $stable(nib_q) && $stable(raddr_q));

    // Transmit start returns the read side to its origin.
    assert_rd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (raddr_q == '0) && (nib_q == '0));

endmodule

// File: rtl/nibport_top.sv
// Nibble-stream packet buffer port: decodes host bytes, assembles written
// nibbles into buffer bytes and serves buffer bytes back as nibbles on
// status lines 6..3.
// Assumes the buffer is a simple synchronous dual-port memory.
module nibport_top
    import nibport_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xmit_start,
    input  logic              host_strobe,
    input  logic [7:0]        host_data,
    output logic [7:0]        host_status,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_waddr,
    output logic [7:0]        buf_wdata,
    output logic              buf_re,
    output logic [ADDR_W-1:0] buf_raddr,
    input  logic [7:0]        buf_rdata
);

    localparam int STATUS_LSB = 3;

    cmd_e       cmd;
    logic [3:0] nib;
    logic [3:0] rd_nib;

    nibport_decode i_decode (
        .strobe (host_strobe),
        .data   (host_data),
        .cmd    (cmd),
        .nib    (nib)
    );

    nibport_wr_asm #(.ADDR_W(ADDR_W)) i_wr_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (xmit_start),
        .cmd       (cmd),
        .nib       (nib),
        .buf_we    (buf_we),
        .buf_waddr (buf_waddr),
        .buf_wdata (buf_wdata)
    );

    nibport_rd_srv #(.ADDR_W(ADDR_W)) i_rd_srv (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (xmit_start),
        .cmd       (cmd),
        .buf_re    (buf_re),
        .buf_raddr (buf_raddr),
        .buf_rdata (buf_rdata),
        .nib_out   (rd_nib)
    );

    // Place the served nibble on status lines 6..3, all else low.
    always_comb begin
        host_status = '0;
        host_status[STATUS_LSB +: 4] = rd_nib;
    end

    // The write and read paths are never active in the same cycle.
    assert_path_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && buf_re));

endmodule

// File: tb/test_nibport_top.sv
`timescale 1ns/1ps
module test_nibport_top;

    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xmit_start = 1'b0;
    logic              host_strobe = 1'b0;
    logic [7:0]        host_data = '0;
    logic [7:0]        host_status;
    logic              buf_we;
    logic [ADDR_W-1:0] buf_waddr;
    logic [7:0]        buf_wdata;
    logic              buf_re;
    logic [ADDR_W-1:0] buf_raddr;
    logic [7:0]        buf_rdata = '0;

    logic [7:0] mem [0:DEPTH-1];
    int         wr_count = 0;
    int         last_waddr = -1;
    int         checks = 0;
    int         fails = 0;

    always #4 clk = ~clk;

    nibport_top #(.ADDR_W(ADDR_W)) i_nibport_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .xmit_start  (xmit_start),
        .host_strobe (host_strobe),
        .host_data   (host_data),
        .host_status (host_status),
        .buf_we      (buf_we),
        .buf_waddr   (buf_waddr),
        .buf_wdata   (buf_wdata),
        .buf_re      (buf_re),
        .buf_raddr   (buf_raddr),
        .buf_rdata   (buf_rdata)
    );

    // Buffer model: synchronous write and one-cycle read.
    always @(posedge clk) begin
        if (buf_we) begin
            mem[buf_waddr] <= buf_wdata;
            wr_count       <= wr_count + 1;
            last_waddr     <= int'(buf_waddr);
        end
        if (buf_re)
            buf_rdata <= mem[buf_raddr];
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        host_strobe = 1'b1;
        host_data   = b;
        @(negedge clk);
        host_strobe = 1'b0;
        host_data   = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_xmit();
        @(negedge clk);
        xmit_start = 1'b1;
        @(negedge clk);
        xmit_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        send({4'h0, v[3:0]});
        send({4'h1, v[7:4]});
    endtask

    function automatic int st(input logic [3:0] n);
        return int'({1'b0, n, 3'b000});
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", int'(host_status), 0);
        chk("R1 no write after reset", wr_count, 0);
    endtask

    task automatic t_write_bytes();
        int base;
        base = wr_count;
        send(8'h05);
        chk("R2 low nibble alone writes nothing", wr_count, base);
        send(8'h1A);
        chk("R1 first byte lands at address 0", last_waddr, 0);
        chk("R3 assembled byte", int'(mem[0]), 8'hA5);
        send_byte(8'h3C);
        chk("R3 second byte next address", int'(mem[1]), 8'h3C);
        chk("R3 write count", wr_count, base + 2);
    endtask

    task automatic t_orphan();
        int base;
        base = wr_count;
        send(8'h17);
        chk("R4 orphan high writes nothing", wr_count, base);
        send(8'h02);
        send(8'h19);
        chk("R4 realign after orphan", int'(mem[2]), 8'h92);
        send(8'h04);
        send(8'h06);
        send(8'h1B);
        chk("R4 later low nibble kept", int'(mem[3]), 8'hB6);
        chk("R4 only one write for double low", last_waddr, 3);
    endtask

    task automatic t_word();
        logic [15:0] w;
        w = 16'hBEEF;
        send({4'h0, w[3:0]});
        send({4'h1, w[7:4]});
        send({4'h0, w[11:8]});
        send({4'h1, w[15:12]});
        chk("R5 word low byte", int'(mem[4]), 8'hEF);
        chk("R5 word high byte", int'(mem[5]), 8'hBE);
    endtask

    task automatic t_ignore();
        int base;
        logic [7:0] s0;
        base = wr_count;
        s0 = host_status;
        send(8'h01);
        send(8'h3F);
        send(8'h5A);
        send(8'hCD);
        send(8'hDD);
        send(8'hFF);
        chk("R6 foreign bytes write nothing", wr_count, base);
        chk("R6 foreign bytes keep status", int'(host_status), int'(s0));
        send(8'h17);
        chk("R6 pending nibble survives foreign bytes", int'(mem[6]), 8'h71);
    endtask

    task automatic t_read_back();
        logic [7:0] exp [0:6];
        exp[0] = 8'hA5; exp[1] = 8'h3C; exp[2] = 8'h92; exp[3] = 8'hB6;
        exp[4] = 8'hEF; exp[5] = 8'hBE; exp[6] = 8'h71;
        pulse_xmit();
        for (int i = 0; i < 7; i++) begin
            send(8'hCE);
            chk($sformatf("R7 low half byte %0d", i), int'(host_status), st(exp[i][3:0]));
            send(8'hDE);
            chk($sformatf("R8 high half byte %0d", i), int'(host_status), st(exp[i][7:4]));
        end
    endtask

    task automatic t_repeat();
        pulse_xmit();
        send(8'hCE);
        send(8'hCE);
        chk("R9 repeated low keeps nibble", int'(host_status), st(4'h5));
        send(8'hDE);
        send(8'hDE);
        chk("R9 repeated high keeps nibble", int'(host_status), st(4'hA));
        send(8'hCE);
        chk("R9 repeated high advanced once", int'(host_status), st(4'hC));
    endtask

    task automatic t_xmit();
        int base;
        base = wr_count;
        send(8'h03);
        pulse_xmit();
        chk("R10 status cleared", int'(host_status), 0);
        send(8'h14);
        chk("R10 held nibble dropped", wr_count, base);
        send_byte(8'h87);
        chk("R10 write restarts at 0", last_waddr, 0);
        chk("R10 byte at 0", int'(mem[0]), 8'h87);
        send(8'hCE);
        chk("R10 read restarts at 0", int'(host_status), st(4'h7));
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
        t_reset();
        t_write_bytes();
        t_orphan();
        t_word();
        t_ignore();
        t_read_back();
        t_repeat();
        t_xmit();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule